// File: doc/BRIEF.md
# Triggered Circular Capture Controller

This block sits between a free-running sample source and a circular capture RAM. Each valid sample is written at a write pointer that wraps over a buffer of 2^ADDR_W words. While the block rests it only records. A search command takes a snapshot of the trigger settings: a threshold, a direction and a filter code that sets how many consecutive qualifying samples are needed. The block then keeps recording and also watches for that run of samples.

When the trigger qualifies, the block writes a fixed number of further samples. That number is derived from a pre-trigger percentage, so the buffer ends up holding that share of data from before the trigger. Writing then stops. A read request is raised together with the address of the oldest sample in the buffer. The request is held until the readout side signals that the transfer is complete. The block then goes back to plain recording, ready for the next search command, with no reset needed.

The controller has four named states: ST_IDLE (recording only), ST_SEARCH (recording and qualifying), ST_POST (recording the post-trigger tail) and ST_READOUT (writes frozen, read request held). It has six named transitions:
- ARM: ST_IDLE to ST_SEARCH.
- REARM: ST_SEARCH to itself, with the hit count cleared.
- ABANDON: ST_SEARCH to ST_IDLE, when the settings are withdrawn.
- TRIG: ST_SEARCH to ST_POST, or straight to ST_READOUT when the tail is empty.
- FULL: ST_POST to ST_READOUT.
- RELEASE: ST_READOUT to ST_IDLE.

Top module: `trig_capture`

## Requirements
- R1: Every cycle with `smp_valid` high, outside ST_READOUT, raises `ram_we` with `ram_wdata` equal to `smp_data`. `ram_addr` then advances by one, modulo 2^ADDR_W. `ram_addr` never changes in a cycle without a write.
- R2: A search starts only on `arm` while `cfg_valid` is high and `cfg_pct` is at most 100. Otherwise the block keeps recording and never raises `rd_en`, whatever samples arrive.
- R3: With `cfg_below` = 0 a sample qualifies when it is strictly greater than `cfg_level`. With `cfg_below` = 1 it qualifies when it is strictly smaller. A sample equal to the level never qualifies.
- R4: `cfg_filter` codes 0, 1, 2 and 3 require 1, 2, 4 and 8 consecutive qualifying valid samples. A valid non-qualifying sample clears the run. Cycles with `smp_valid` low leave the run unchanged.
- R5: The trigger sample is written as the last pre-trigger sample. After it, exactly floor(2^ADDR_W × (100 − pct) / 100) valid samples are written, where pct is the value captured at `arm`. Changing `cfg_pct` after `arm` has no effect.
- R6: After the last post-trigger write, `ram_we` stays low and `rd_en` is high. `rd_start` equals the address that follows the last write. `rd_en` and `rd_start` hold until `rd_done`.
- R7: `rd_done` during ST_READOUT drops `rd_en` on the next cycle. Recording resumes at `rd_start`, and a new `arm` is needed before another trigger.
- R8: `arm` during ST_SEARCH clears the hit run and snapshots the settings again. `cfg_valid` low during ST_SEARCH returns the block to ST_IDLE.
- R9: After reset the block is in ST_IDLE, with `ram_addr` at 0 and `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DATA_W | Sample value (unsigned) |
| cfg_valid | input | 1 | Settings are complete |
| cfg_level | input | DATA_W | Trigger threshold |
| cfg_below | input | 1 | 0: fire above level, 1: fire below level |
| cfg_filter | input | 2 | Consecutive-hit code (1, 2, 4, 8) |
| cfg_pct | input | 7 | Pre-trigger percentage, 0 to 100 |
| arm | input | 1 | Search command pulse |
| rd_done | input | 1 | Readout finished |
| ram_we | output | 1 | Capture RAM write enable |
| ram_addr | output | ADDR_W | Capture RAM write address |
| ram_wdata | output | DATA_W | Capture RAM write data |
| rd_en | output | 1 | Read request to readout logic |
| rd_start | output | ADDR_W | Oldest-sample address for readout |

## Verification
The hardest case to reach is a trigger that must not fire. Examples are a run one hit short that is broken by a sample exactly at the level, a run that straddles a re-arm, and a run interrupted by idle cycles that must not break it. The only evidence at the ports is that `rd_en` rises later, or not at all. The stimulus therefore builds each pre-trigger pattern explicitly: equal-to-level samples, partial runs and gaps. It then counts the writes between the intended trigger sample and the rise of `rd_en`. A trigger that comes too early or too late shows up as a wrong tail length and a wrong start address. A scoreboard compares that start address against the value predicted from the trigger address.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int FILT_W  = 2;
    localparam int PCT_W   = 7;
    localparam int PCT_MAX = 100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_POST,
        ST_READOUT
    } cap_state_e;
endpackage

// File: rtl/cap_wr_ptr.sv
module cap_wr_ptr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    output logic [ADDR_W-1:0] ptr_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else if (step_i) begin
            ptr_o <= ptr_o + 1'b1;
        end
    end
endmodule

// File: rtl/cap_hit_filter.sv
module cap_hit_filter
    import cap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              restart_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] level_i,
    input  logic              below_i,
    input  logic [FILT_W-1:0] code_i,
    output logic              fire_o
);
    localparam int CODES = 1 << FILT_W;
    localparam int CNT_W = CODES + 1;

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_inc;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] need_tab [CODES];
    logic             hit;

    genvar g;
    generate
        for (g = 0; g < CODES; g++) begin : g_need
            assign need_tab[g] = CNT_W'(1) << g;
        end
    endgenerate

    always_comb begin
        need    = need_tab[code_i];
        hit     = below_i ? (data_i < level_i) : (data_i > level_i);
        run_inc = run_q + CNT_W'(1);
        fire_o  = enable_i && !restart_i && valid_i && hit && (run_inc >= need);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!enable_i || restart_i) begin
            run_q <= '0;
        end else if (valid_i) begin
            run_q <= hit ? run_inc : '0;
        end
    end
endmodule

// File: rtl/cap_post_len.sv
module cap_post_len
    import cap_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [PCT_W-1:0] pct_i,
    output logic [ADDR_W:0]  len_o
);
    localparam int PROD_W = ADDR_W + PCT_W + 1;

    logic [PCT_W-1:0]  share;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        share = PCT_W'(PCT_MAX) - pct_i;
        prod  = PROD_W'(share) << ADDR_W;
        quot  = prod / PROD_W'(PCT_MAX);
        len_o = (ADDR_W + 1)'(quot);
    end
endmodule

// File: rtl/trig_capture.sv
module trig_capture
    import cap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              cfg_valid,
    input  logic [DATA_W-1:0] cfg_level,
    input  logic              cfg_below,
    input  logic [FILT_W-1:0] cfg_filter,
    input  logic [PCT_W-1:0]  cfg_pct,
    input  logic              arm,
    input  logic              rd_done,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_start
);
    localparam int LEN_W = ADDR_W + 1;

    cap_state_e        state_q, state_d;
    logic              cfg_ok;
    logic              arm_take;
    logic              wr_go;
    logic              trig;
    logic [ADDR_W-1:0] ptr;
    logic [LEN_W-1:0]  post_len;
    logic [LEN_W-1:0]  rem_q;
    logic [DATA_W-1:0] lvl_q;
    logic              below_q;
    logic [FILT_W-1:0] code_q;
    logic [PCT_W-1:0]  pct_q;

    // settings accepted only when complete and in range
    assign cfg_ok   = cfg_valid && (cfg_pct <= PCT_W'(PCT_MAX));
    assign arm_take = arm && cfg_ok && (state_q == ST_IDLE || state_q == ST_SEARCH);

    // snapshot of the search settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            below_q <= 1'b0;
            code_q  <= '0;
            pct_q   <= '0;
        end else if (arm_take) begin
            lvl_q   <= cfg_level;
            below_q <= cfg_below;
            code_q  <= cfg_filter;
            pct_q   <= cfg_pct;
        end
    end

    cap_wr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (wr_go),
        .ptr_o  (ptr)
    );

    cap_hit_filter #(.DATA_W(DATA_W)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (state_q == ST_SEARCH && cfg_valid),
        .restart_i (arm_take),
        .valid_i   (smp_valid),
        .data_i    (smp_data),
        .level_i   (lvl_q),
        .below_i   (below_q),
        .code_i    (code_q),
        .fire_o    (trig)
    );

    cap_post_len #(.ADDR_W(ADDR_W)) u_len (
        .pct_i (pct_q),
        .len_o (post_len)
    );

    // post-trigger countdown, loaded on trigger
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (trig) begin
            rem_q <= post_len;
        end else if (state_q == ST_POST && smp_valid) begin
            rem_q <= rem_q - LEN_W'(1);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_take) state_d = ST_SEARCH;              // ARM
            end
            ST_SEARCH: begin
                if (!cfg_valid) begin
                    state_d = ST_IDLE;                          // ABANDON
                end else if (arm_take) begin
                    state_d = ST_SEARCH;                        // REARM
                end else if (trig) begin                        // TRIG
                    state_d = (post_len == '0) ? ST_READOUT : ST_POST;
                end
            end
            ST_POST: begin
                if (smp_valid && rem_q == LEN_W'(1)) state_d = ST_READOUT; // FULL
            end
            ST_READOUT: begin
                if (rd_done) state_d = ST_IDLE;                 // RELEASE
            end
        endcase
    end

    // outputs
    always_comb begin
        wr_go     = smp_valid && (state_q != ST_READOUT);
        ram_we    = wr_go;
        ram_addr  = ptr;
        ram_wdata = smp_data;
        rd_en     = (state_q == ST_READOUT);
        rd_start  = ptr;
    end
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic              rd_done,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_start
);
    assert_we_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> smp_valid);

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> ram_addr == $past(ram_addr) + 1'b1);

    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we |=> $stable(ram_addr));

    assert_rise_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> $past(ram_we));

    assert_no_write_readout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !ram_we);

    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_done) |=> (rd_en && $stable(rd_start)));

    assert_rd_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_done) |=> !rd_en);
endmodule

bind trig_capture cap_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .rd_done   (rd_done),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .rd_en     (rd_en),
    .rd_start  (rd_start)
);

// File: tb/tb_trig_capture.sv
module tb_trig_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = '0;
    logic       cfg_valid = 1'b0;
    logic [7:0] cfg_level = '0;
    logic       cfg_below = 1'b0;
    logic [1:0] cfg_filter = '0;
    logic [6:0] cfg_pct = '0;
    logic       arm = 1'b0;
    logic       rd_done = 1'b0;
    logic       ram_we;
    logic [7:0] ram_addr;
    logic [7:0] ram_wdata;
    logic       rd_en;
    logic [7:0] rd_start;

    int         n_run = 0;
    int         n_bad = 0;
    bit         ended = 1'b0;
    logic [7:0] exp_addr = '0;
    logic       s_we, s_rd;
    logic [7:0] s_addr;
    logic [7:0] sb_q[$];
    logic       rd_prev = 1'b0;

    always #5 clk = ~clk;

    trig_capture dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_valid(cfg_valid), .cfg_level(cfg_level), .cfg_below(cfg_below),
        .cfg_filter(cfg_filter), .cfg_pct(cfg_pct), .arm(arm), .rd_done(rd_done),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .rd_en(rd_en), .rd_start(rd_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops the predicted start address on each read request
    always @(negedge clk) begin
        if (rst_n && rd_en && !rd_prev) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R6 unexpected read request", rd_start, -1);
            end else begin
                logic [7:0] e;
                e = sb_q.pop_front();
                chk(rd_start == e, "R6 rd_start", rd_start, e);
            end
        end
        rd_prev = rd_en;
    end

    // one cycle: drive, sample mid-cycle, check R1 write path
    task automatic step(input logic v, input logic [7:0] d);
        smp_valid = v;
        smp_data  = d;
        @(negedge clk);
        s_we   = ram_we;
        s_addr = ram_addr;
        s_rd   = rd_en;
        if (s_we) begin
            if (s_addr != exp_addr || ram_wdata != d)
                chk(1'b0, "R1 write addr/data", s_addr, exp_addr);
            exp_addr = exp_addr + 8'd1;
        end
        @(posedge clk);
        #1;
        arm     = 1'b0;
        rd_done = 1'b0;
    endtask

    task automatic capture(input logic [7:0] lvl, input logic below, input logic [1:0] code,
                           input int pct, input int noise_n, input int partial, input bit chg_pct);
        int         need;
        int         tail;
        int         cnt;
        logic [7:0] hitv, eqv, start_e;
        need = 1 << code;
        tail = (256 * (100 - pct)) / 100;
        hitv = below ? lvl - 8'd1 : lvl + 8'd1;
        eqv  = lvl;
        cfg_valid = 1'b1; cfg_level = lvl; cfg_below = below;
        cfg_filter = code; cfg_pct = 7'(pct);
        arm = 1'b1;
        step(1'b0, 8'd0);
        for (int i = 0; i < noise_n; i++) step(1'b1, eqv);       // R3 equal never fires
        for (int i = 0; i < partial; i++) step(1'b1, hitv);
        if (partial > 0) step(1'b1, eqv);                         // R4 run broken
        chk(!s_rd, "R3/R4 no early trigger", s_rd, 0);
        for (int i = 0; i < need; i++) begin
            if (i == 1) step(1'b0, eqv);                          // R4 gap keeps run
            step(1'b1, hitv);
            if (i < need - 1) chk(!s_rd, "R4 run below count", s_rd, 0);
        end
        start_e = s_addr + 8'd1 + 8'(tail);
        sb_q.push_back(start_e);
        if (chg_pct) cfg_pct = 7'd0;                              // R5 ignored after arm
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            step(1'b1, 8'(i));
            if (s_rd) break;
            if (s_we) cnt++;
        end
        chk(cnt == tail, "R5 post-trigger write count", cnt, tail);
        chk(s_rd && !s_we, "R6 write frozen with read request", s_we, 0);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 8'h55);
            chk(s_rd && !s_we, "R6 hold until done", s_rd, 1);
        end
        rd_done = 1'b1;
        step(1'b1, 8'h66);
        step(1'b1, 8'h77);
        chk(!s_rd && s_we && s_addr == start_e, "R7 resume at start address", s_addr, start_e);
        for (int i = 0; i < 12; i++) step(1'b1, hitv);
        chk(!s_rd, "R7 no trigger without new arm", s_rd, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk(ram_addr == 8'd0 && !rd_en && !ram_we, "R9 reset state", ram_addr, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: plain recording with wrap
        for (int i = 0; i < 260; i++) step(i % 3 != 0, 8'(i));
        chk(!s_rd && s_addr == exp_addr - 8'd1, "R1 wrap recording", s_addr, exp_addr - 8'd1);

        // R2: incomplete settings, then out-of-range percentage
        cfg_valid = 1'b0; cfg_level = 8'd10; cfg_below = 1'b0; cfg_filter = 2'd0; cfg_pct = 7'd50;
        arm = 1'b1;
        step(1'b0, 8'd0);
        for (int i = 0; i < 20; i++) step(1'b1, 8'd200);
        chk(!s_rd && s_we, "R2 invalid settings stay idle", s_rd, 0);
        cfg_valid = 1'b1; cfg_pct = 7'd101;
        arm = 1'b1;
        step(1'b0, 8'd0);
        for (int i = 0; i < 20; i++) step(1'b1, 8'd200);
        chk(!s_rd && s_we, "R2 pct above 100 stays idle", s_rd, 0);

        // R8: re-arm clears the run; withdrawn settings abandon search
        cfg_pct = 7'd50; cfg_filter = 2'd1; cfg_level = 8'd100; cfg_below = 1'b0;
        arm = 1'b1;
        step(1'b0, 8'd0);
        step(1'b1, 8'd150);
        arm = 1'b1;
        step(1'b0, 8'd0);
        step(1'b1, 8'd150);
        step(1'b1, 8'd90);
        chk(!s_rd, "R8 re-arm clears hit run", s_rd, 0);
        cfg_valid = 1'b0;
        step(1'b0, 8'd0);
        cfg_valid = 1'b1;
        for (int i = 0; i < 10; i++) step(1'b1, 8'd150);
        chk(!s_rd, "R8 abandoned search stays idle", s_rd, 0);

        // R3..R7 full captures, several directions, filters and shares
        capture(8'd100, 1'b0, 2'd0, 50, 2, 0, 1'b0);
        capture(8'd200, 1'b1, 2'd2, 25, 3, 3, 1'b0);
        capture(8'd50,  1'b0, 2'd3, 0,  1, 5, 1'b0);
        capture(8'd128, 1'b1, 2'd1, 100, 2, 1, 1'b0);
        capture(8'd10,  1'b0, 2'd1, 33, 0, 1, 1'b1);

        chk(sb_q.size() == 0, "R6 every predicted read request seen", sb_q.size(), 0);
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_run++;
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule